// File: doc/BRIEF.md
# Boot-Time ROM Hash Checker

This block runs exactly once after reset to establish whether the contents of a read-only memory are intact. It walks the memory from the bottom up and hands every word below the top eight to an external hash engine. The top eight words are not hashed: they hold the expected 256-bit digest, stored without scrambling. When the engine reports its result, the block recombines the digest, compares it with the expected value and publishes a sticky verdict. A power controller waits for `chk_done_o` before releasing the processor. A key-derivation block consumes `dig_data_o` once `dig_valid_o` is high.

The ROM port is a plain request port with a fixed one-cycle read latency: data for a request made in cycle t is on `rom_rdata_i` throughout cycle t+1. The data path toward the engine is a valid/ready stream with these rules:
- A beat transfers on a rising edge where `hs_valid_o` and `hs_ready_i` are both high.
- While `hs_ready_i` is low, `hs_valid_o`, `hs_data_o` and `hs_last_o` hold their values. The engine may hold ready low for any number of cycles.
- The block never withdraws a beat once it has offered it.

The engine's result port is a single-cycle `eng_done_i` pulse with two digest shares. The block treats a completion pulse that arrives while it is not waiting for one as a fault. On such a pulse it raises a sticky fatal alert and stops all activity. An illegal encoding of its sparse state register has the same effect.

Top module: `rom_hash_checker`

## Requirements
- R1: While reset is asserted: `chk_done_o`=0, `chk_good_o`=4'h9 (false), `dig_valid_o`=0, `alert_o`=0 and `hs_valid_o`=0.
- R2: ROM requests come in a fixed order, with no address requested twice. First, one per cycle, the addresses ROM_WORDS-8 up to ROM_WORDS-1. Then the addresses 0 up to ROM_WORDS-9, in increasing order.
- R3: Each beat carries one hashed ROM word. The 39-bit word sits in bits [38:0] and bits [63:39] are zero. `hs_strb_o` is zero on every beat.
- R4: Exactly ROM_WORDS-8 beats are sent, in increasing address order. While valid is high and ready is low, the valid, data and last outputs hold.
- R5: `hs_last_o` is high only together with `hs_valid_o`, and only on the beat for address ROM_WORDS-9.
- R6: The expected digest uses only the low 32 bits of each top word; the upper 7 bits are ignored. Word ROM_WORDS-8+k supplies digest bits [32k+31:32k].
- R7: The computed digest is `eng_share0_i` XOR `eng_share1_i`, sampled on the accepted `eng_done_i`. It appears on `dig_data_o`, with `dig_valid_o` high, in the next cycle.
- R8: `chk_done_o` rises in the same cycle as `dig_valid_o`. `chk_good_o` is 4'h6 if the computed digest equals the expected one and 4'h9 otherwise. It reads 4'h9 before done.
- R9: Once high, `chk_done_o` and `dig_valid_o` stay high until reset, and `chk_good_o` and `dig_data_o` stay constant. This holds even if further `eng_done_i` pulses arrive.
- R10: After the last beat has transferred, `hs_valid_o` and `rom_req_o` are never asserted again.
- R11: An `eng_done_i` pulse while not waiting for the digest raises `alert_o` in the next cycle. The alert stays high until reset. From then on there are no ROM requests and no beats, and `chk_done_o` stays low if it was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rom_req_o | output | 1 | ROM read request |
| rom_addr_o | output | $clog2(ROM_WORDS) | Logical ROM word address |
| rom_rdata_i | input | ROM_W | ROM word, valid the cycle after the request |
| hs_valid_o | output | 1 | Beat valid toward the hash engine |
| hs_ready_i | input | 1 | Hash engine accepts a beat |
| hs_data_o | output | BEAT_W | Zero-extended ROM word |
| hs_strb_o | output | BEAT_W/8 | Byte strobe, always zero |
| hs_last_o | output | 1 | Marks the final beat |
| eng_done_i | input | 1 | Hash engine completion pulse |
| eng_share0_i | input | DIG_W | Digest share 0 |
| eng_share1_i | input | DIG_W | Digest share 1 |
| chk_done_o | output | 1 | Check complete (sticky) |
| chk_good_o | output | 4 | Verdict: 4'h6 true, 4'h9 false |
| dig_valid_o | output | 1 | Digest output valid (sticky) |
| dig_data_o | output | DIG_W | Recombined digest |
| alert_o | output | 1 | Sticky fatal alert |

## Verification
The bench runs with three ready patterns: always ready, pseudo-random and every third cycle. In the back-pressured runs the first cycle of a beat comes straight from the ROM and later cycles come from a holding register. A design that dropped that register would present zeros or stale data under back-pressure. The top words carry non-zero upper bits, so a design that kept them, or that placed them in the wrong slot, would report a false verdict on an intact image. A corrupted image must yield 4'h9 together with the true digest. Digest shares with a non-trivial mask catch a design that uses only one share. Completion pulses are injected mid-stream and after done. These catch a design that fails to alert, keeps streaming after the alert, or overwrites its sticky verdict.

// File: rtl/rom_hash_pkg.sv
package rom_hash_pkg;

  // Sparse state codes, every pair at Hamming distance 3 or more.
  typedef enum logic [5:0] {
    ST_TOP   = 6'b000111,
    ST_BREQ  = 6'b011001,
    ST_BSEND = 6'b101010,
    ST_WAIT  = 6'b110100,
    ST_DONE  = 6'b111111,
    ST_ALERT = 6'b000000
  } chk_state_e;

  localparam logic [3:0] MB4_TRUE  = 4'h6;
  localparam logic [3:0] MB4_FALSE = 4'h9;

endpackage

// File: rtl/rom_hash_seq.sv
module rom_hash_seq
  import rom_hash_pkg::*;
#(
  parameter int ROM_WORDS = 64,
  parameter int TOP_WORDS = 8,
  parameter int ROM_W     = 39,
  parameter int BEAT_W    = 64,
  localparam int AW       = $clog2(ROM_WORDS),
  localparam int TIW      = $clog2(TOP_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              rom_req_o,
  output logic [AW-1:0]     rom_addr_o,
  input  logic [ROM_W-1:0]  rom_rdata_i,
  output logic              hs_valid_o,
  input  logic              hs_ready_i,
  output logic [BEAT_W-1:0] hs_data_o,
  output logic              hs_last_o,
  input  logic              eng_done_i,
  output logic              top_fire_o,
  output logic [TIW-1:0]    top_idx_o,
  output logic              take_o,
  output logic              alert_o
);

  localparam int BODY = ROM_WORDS - TOP_WORDS;
  localparam logic [AW-1:0]  TOP_BASE  = AW'(BODY);
  localparam logic [AW-1:0]  BODY_LAST = AW'(BODY - 1);
  localparam logic [TIW-1:0] TOP_LAST  = TIW'(TOP_WORDS - 1);

  chk_state_e state_q, state_d;
  logic [TIW-1:0]   top_cnt_q;
  logic [AW-1:0]    body_cnt_q;
  logic             fresh_q;
  logic [ROM_W-1:0] hold_q;
  logic             alert_q;
  logic             illegal;
  logic             spurious;
  logic             is_last;
  logic             xfer;
  logic [ROM_W-1:0] word;

  assign is_last  = (body_cnt_q == BODY_LAST);
  assign xfer     = hs_valid_o && hs_ready_i;
  assign spurious = eng_done_i && (state_q != ST_WAIT);
  assign word     = fresh_q ? rom_rdata_i : hold_q;

  always_comb begin
    state_d    = state_q;
    rom_req_o  = 1'b0;
    rom_addr_o = '0;
    hs_valid_o = 1'b0;
    illegal    = 1'b0;
    unique case (state_q)
      ST_TOP: begin
        rom_req_o  = 1'b1;
        rom_addr_o = TOP_BASE + AW'(top_cnt_q);
        if (top_cnt_q == TOP_LAST) state_d = ST_BREQ;
      end
      ST_BREQ: begin
        rom_req_o  = 1'b1;
        rom_addr_o = body_cnt_q;
        state_d    = ST_BSEND;
      end
      ST_BSEND: begin
        hs_valid_o = 1'b1;
        if (hs_ready_i) state_d = is_last ? ST_WAIT : ST_BREQ;
      end
      ST_WAIT: begin
        if (eng_done_i) state_d = ST_DONE;
      end
      ST_DONE:  state_d = ST_DONE;
      ST_ALERT: state_d = ST_ALERT;
      default: begin
        illegal = 1'b1;
        state_d = ST_ALERT;
      end
    endcase
    if (spurious) state_d = ST_ALERT;
  end

  assign hs_data_o  = {{(BEAT_W-ROM_W){1'b0}}, word};
  assign hs_last_o  = hs_valid_o && is_last;
  assign top_fire_o = (state_q == ST_TOP);
  assign top_idx_o  = top_cnt_q;
  assign take_o     = (state_q == ST_WAIT) && eng_done_i;
  assign alert_o    = alert_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_TOP;
      top_cnt_q  <= '0;
      body_cnt_q <= '0;
      fresh_q    <= 1'b0;
      hold_q     <= '0;
      alert_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      alert_q <= alert_q | spurious | illegal;
      if (state_q == ST_TOP) top_cnt_q <= top_cnt_q + 1'b1;
      if (xfer && !is_last) body_cnt_q <= body_cnt_q + 1'b1;
      fresh_q <= (state_q == ST_BREQ) && (state_d == ST_BSEND);
      if (fresh_q) hold_q <= rom_rdata_i;
    end
  end

endmodule

// File: rtl/rom_hash_expect.sv
module rom_hash_expect #(
  parameter int KEEP_W    = 32,
  parameter int TOP_WORDS = 8,
  localparam int TIW      = $clog2(TOP_WORDS),
  localparam int DIG_W    = KEEP_W * TOP_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [TIW-1:0]    idx_i,
  input  logic [KEEP_W-1:0] rdata_i,
  output logic [DIG_W-1:0]  exp_o
);

  logic           cap_v_q;
  logic [TIW-1:0] cap_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_v_q   <= 1'b0;
      cap_idx_q <= '0;
    end else begin
      cap_v_q   <= fire_i;
      cap_idx_q <= idx_i;
    end
  end

  for (genvar k = 0; k < TOP_WORDS; k++) begin : g_slot
    logic [KEEP_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
      end else if (cap_v_q && (cap_idx_q == TIW'(k))) begin
        slot_q <= rdata_i;
      end
    end
    assign exp_o[k*KEEP_W +: KEEP_W] = slot_q;
  end

endmodule

// File: rtl/rom_hash_result.sv
module rom_hash_result
  import rom_hash_pkg::*;
#(
  parameter int DIG_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [DIG_W-1:0] share0_i,
  input  logic [DIG_W-1:0] share1_i,
  input  logic [DIG_W-1:0] exp_i,
  output logic             done_o,
  output logic [3:0]       good_o,
  output logic [DIG_W-1:0] dig_o
);

  logic [DIG_W-1:0] joined;
  logic             match;
  logic             done_q;
  logic [3:0]       good_q;
  logic [DIG_W-1:0] dig_q;

  assign joined = share0_i ^ share1_i;
  assign match  = (joined == exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      good_q <= MB4_FALSE;
      dig_q  <= '0;
    end else if (take_i && !done_q) begin
      done_q <= 1'b1;
      good_q <= match ? MB4_TRUE : MB4_FALSE;
      dig_q  <= joined;
    end
  end

  assign done_o = done_q;
  assign good_o = good_q;
  assign dig_o  = dig_q;

endmodule

// File: rtl/rom_hash_checker.sv
module rom_hash_checker #(
  parameter int ROM_WORDS = 64,
  parameter int ROM_W     = 39,
  parameter int KEEP_W    = 32,
  parameter int BEAT_W    = 64,
  parameter int DIG_W     = 256,
  localparam int AW       = $clog2(ROM_WORDS),
  localparam int TOP_WORDS = DIG_W / KEEP_W,
  localparam int TIW      = $clog2(TOP_WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic                rom_req_o,
  output logic [AW-1:0]       rom_addr_o,
  input  logic [ROM_W-1:0]    rom_rdata_i,
  output logic                hs_valid_o,
  input  logic                hs_ready_i,
  output logic [BEAT_W-1:0]   hs_data_o,
  output logic [BEAT_W/8-1:0] hs_strb_o,
  output logic                hs_last_o,
  input  logic                eng_done_i,
  input  logic [DIG_W-1:0]    eng_share0_i,
  input  logic [DIG_W-1:0]    eng_share1_i,
  output logic                chk_done_o,
  output logic [3:0]          chk_good_o,
  output logic                dig_valid_o,
  output logic [DIG_W-1:0]    dig_data_o,
  output logic                alert_o
);

  logic             top_fire;
  logic [TIW-1:0]   top_idx;
  logic             take;
  logic [DIG_W-1:0] exp_dig;

  rom_hash_seq #(
    .ROM_WORDS(ROM_WORDS), .TOP_WORDS(TOP_WORDS),
    .ROM_W(ROM_W), .BEAT_W(BEAT_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rom_req_o(rom_req_o), .rom_addr_o(rom_addr_o), .rom_rdata_i(rom_rdata_i),
    .hs_valid_o(hs_valid_o), .hs_ready_i(hs_ready_i),
    .hs_data_o(hs_data_o), .hs_last_o(hs_last_o),
    .eng_done_i(eng_done_i),
    .top_fire_o(top_fire), .top_idx_o(top_idx),
    .take_o(take), .alert_o(alert_o)
  );

  rom_hash_expect #(.KEEP_W(KEEP_W), .TOP_WORDS(TOP_WORDS)) u_expect (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fire_i(top_fire), .idx_i(top_idx),
    .rdata_i(rom_rdata_i[KEEP_W-1:0]),
    .exp_o(exp_dig)
  );

  rom_hash_result #(.DIG_W(DIG_W)) u_result (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .take_i(take), .share0_i(eng_share0_i), .share1_i(eng_share1_i),
    .exp_i(exp_dig),
    .done_o(chk_done_o), .good_o(chk_good_o), .dig_o(dig_data_o)
  );

  assign dig_valid_o = chk_done_o;
  assign hs_strb_o   = '0;

endmodule

// File: rtl/rom_hash_checker_sva.sv
module rom_hash_checker_sva #(
  parameter int BEAT_W = 64,
  parameter int DIG_W  = 256
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rom_req_o,
  input logic                hs_valid_o,
  input logic                hs_ready_i,
  input logic [BEAT_W-1:0]   hs_data_o,
  input logic [BEAT_W/8-1:0] hs_strb_o,
  input logic                hs_last_o,
  input logic                eng_done_i,
  input logic                chk_done_o,
  input logic [3:0]          chk_good_o,
  input logic                dig_valid_o,
  input logic [DIG_W-1:0]    dig_data_o,
  input logic                alert_o
);

  logic last_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_seen_q <= 1'b0;
    else if (hs_valid_o && hs_ready_i && hs_last_o) last_seen_q <= 1'b1;
  end

  a_r3_strb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |-> (hs_strb_o == '0));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_valid_o && !hs_ready_i && !eng_done_i) |=>
      (hs_valid_o && $stable(hs_data_o) && $stable(hs_last_o)));

  a_r5_last_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_last_o |-> hs_valid_o);

  a_r8_good_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_good_o == 4'h6) || (chk_good_o == 4'h9));

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_done_o |=> (chk_done_o && dig_valid_o && $stable(chk_good_o) && $stable(dig_data_o)));

  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_seen_q |-> (!hs_valid_o && !rom_req_o));

  a_r11_alert_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |=> (alert_o && !hs_valid_o && !rom_req_o));

endmodule

bind rom_hash_checker rom_hash_checker_sva #(.BEAT_W(BEAT_W), .DIG_W(DIG_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .rom_req_o(rom_req_o),
  .hs_valid_o(hs_valid_o), .hs_ready_i(hs_ready_i), .hs_data_o(hs_data_o),
  .hs_strb_o(hs_strb_o), .hs_last_o(hs_last_o), .eng_done_i(eng_done_i),
  .chk_done_o(chk_done_o), .chk_good_o(chk_good_o), .dig_valid_o(dig_valid_o),
  .dig_data_o(dig_data_o), .alert_o(alert_o)
);

// File: tb/test_rom_hash_checker.sv
module test_rom_hash_checker;

  localparam int ROMN  = 64;
  localparam int BODYN = 56;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         rom_req;
  logic [5:0]   rom_addr;
  logic [38:0]  rom_rdata = '0;
  logic         hs_valid, hs_ready = 1'b0, hs_last;
  logic [63:0]  hs_data;
  logic [7:0]   hs_strb;
  logic         eng_done = 1'b0;
  logic [255:0] sh0 = '0, sh1 = '0;
  logic         chk_done, dig_valid, alert;
  logic [3:0]   chk_good;
  logic [255:0] dig_data;

  rom_hash_checker i_rom_hash_checker (
    .clk_i(clk), .rst_ni(rst_n),
    .rom_req_o(rom_req), .rom_addr_o(rom_addr), .rom_rdata_i(rom_rdata),
    .hs_valid_o(hs_valid), .hs_ready_i(hs_ready), .hs_data_o(hs_data),
    .hs_strb_o(hs_strb), .hs_last_o(hs_last),
    .eng_done_i(eng_done), .eng_share0_i(sh0), .eng_share1_i(sh1),
    .chk_done_o(chk_done), .chk_good_o(chk_good),
    .dig_valid_o(dig_valid), .dig_data_o(dig_data), .alert_o(alert)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [38:0]  mem [ROMN];
  logic [255:0] h_ref, h_eng, stored_exp, eng_dig;
  int  exp_addr_q [$];
  bit  want_rst, in_reset, pend_v;
  logic [5:0] pend_a;
  int  beats, cd, done_age;
  bit  got_last, eng_fired, done_pend, model_done, alert_pend, model_alert, spur_fired;
  int  ready_mode, spur_mode, eng_delay;
  logic [15:0] lfsr = 16'hACE1;
  bit  prev_hold;
  logic [63:0] prev_data;
  logic prev_last;

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [255:0] step(input logic [255:0] h, input logic [63:0] b, input int i);
    logic [63:0] ix;
    ix = 64'(i);
    return {h[254:0], h[255]} ^ {b ^ ix, ~b, {b[31:0], b[63:32]}, ix * 64'h9E3779B97F4A7C15};
  endfunction

  task automatic setup(input int seed, input bit corrupt);
    h_ref = '0;
    for (int i = 0; i < BODYN; i++) begin
      mem[i] = {7'(i * 5 + seed), 32'(i * 32'h9E3779B9 + seed * 32'h01234567)};
      h_ref = step(h_ref, {25'b0, mem[i]}, i);
    end
    for (int k = 0; k < 8; k++) begin
      mem[BODYN + k] = {7'h5A ^ 7'(k), h_ref[32*k +: 32]};
    end
    if (corrupt) mem[BODYN + 3][9] = ~mem[BODYN + 3][9];
    for (int k = 0; k < 8; k++) stored_exp[32*k +: 32] = mem[BODYN + k][31:0];
    exp_addr_q.delete();
    for (int a = BODYN; a < ROMN; a++) exp_addr_q.push_back(a);
    for (int a = 0; a < BODYN; a++) exp_addr_q.push_back(a);
    beats = 0; cd = 0; done_age = 0; h_eng = '0; eng_dig = '0;
    got_last = 0; eng_fired = 0; done_pend = 0; model_done = 0;
    alert_pend = 0; model_alert = 0; spur_fired = 0; pend_v = 0; prev_hold = 0;
  endtask

  task automatic cycle();
    logic [255:0] mask;
    @(negedge clk);
    rst_n = !want_rst;
    in_reset = want_rst;
    rom_rdata = pend_v ? mem[pend_a] : '0;
    if (done_pend)  begin model_done = 1; done_pend = 0; end
    if (alert_pend) begin model_alert = 1; alert_pend = 0; end
    if (model_done) done_age++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0: hs_ready = 1'b1;
      1: hs_ready = lfsr[0];
      default: hs_ready = (cyc % 3 == 0);
    endcase
    eng_done = 1'b0;
    mask = {8{32'hA5C3_0F1E ^ 32'(cyc)}};
    if (!in_reset) begin
      if (spur_mode == 1 && !spur_fired && beats == 10) begin
        eng_done = 1'b1; hs_ready = 1'b0; sh0 = mask; sh1 = ~mask;
        spur_fired = 1; alert_pend = 1;
      end else if (got_last && !eng_fired) begin
        if (cd == 0) begin
          eng_done = 1'b1; sh0 = mask; sh1 = h_eng ^ mask; eng_dig = h_eng;
          eng_fired = 1; done_pend = 1;
        end else cd--;
      end else if (spur_mode == 2 && !spur_fired && model_done && done_age >= 3) begin
        eng_done = 1'b1; sh0 = ~mask; sh1 = mask ^ 256'h1234;
        spur_fired = 1; alert_pend = 1;
      end
    end
    #1;
    if (in_reset) begin
      check(chk_done == 0, "R1 done", chk_done, 0);
      check(chk_good == 4'h9, "R1 good", chk_good, 4'h9);
      check(dig_valid == 0, "R1 dig_valid", dig_valid, 0);
      check(alert == 0, "R1 alert", alert, 0);
      check(hs_valid == 0, "R1 hs_valid", hs_valid, 0);
      pend_v = 0;
    end else begin
      check(alert == model_alert, "R11 alert", alert, model_alert);
      check(chk_done == model_done, "R9 done", chk_done, model_done);
      if (model_done) begin
        check(chk_good == ((eng_dig == stored_exp) ? 4'h6 : 4'h9), "R8 good", chk_good,
              (eng_dig == stored_exp) ? 4'h6 : 4'h9);
        check(dig_valid == 1, "R7 dig_valid", dig_valid, 1);
        check(dig_data == eng_dig, "R7 digest", dig_data, eng_dig);
      end else begin
        check(chk_good == 4'h9, "R8 good before done", chk_good, 4'h9);
        check(dig_valid == 0, "R7 dig_valid before done", dig_valid, 0);
      end
      pend_v = 0;
      if (rom_req) begin
        if (model_alert) check(0, "R11 read after alert", rom_addr, 0);
        else if (exp_addr_q.size() == 0) check(0, "R10 extra read", rom_addr, 0);
        else begin
          int ea;
          ea = exp_addr_q.pop_front();
          check(rom_addr == 6'(ea), "R2 address", rom_addr, ea);
        end
        pend_v = 1; pend_a = rom_addr;
      end
      check(!hs_last || hs_valid, "R5 last without valid", hs_last, 0);
      if (prev_hold && !model_alert)
        check(hs_valid && hs_data == prev_data && hs_last == prev_last, "R4 hold",
              hs_data, prev_data);
      prev_hold = 0;
      if (hs_valid) begin
        if (model_alert) check(0, "R11 beat after alert", hs_data, 0);
        else if (got_last) check(0, "R10 beat after last", hs_data, 0);
        else begin
          check(hs_strb == 8'h00, "R3 strobe", hs_strb, 0);
          check(hs_data == {25'b0, mem[beats]}, "R3 beat data", hs_data, {25'b0, mem[beats]});
          check(hs_last == (beats == BODYN - 1), "R5 last flag", hs_last, beats == BODYN - 1);
          if (hs_ready) begin
            h_eng = step(h_eng, hs_data, beats);
            if (hs_last) begin got_last = 1; cd = eng_delay; end
            beats++;
          end else begin
            prev_hold = 1; prev_data = hs_data; prev_last = hs_last;
          end
        end
      end
    end
    cyc++;
  endtask

  task automatic run(input int rm, input int spm, input int ed, input int seed, input bit corrupt);
    int post, guard;
    ready_mode = rm; spur_mode = spm; eng_delay = ed;
    setup(seed, corrupt);
    want_rst = 1;
    repeat (3) cycle();
    want_rst = 0;
    post = 0; guard = 0;
    while (post < 12 && guard < 4000) begin
      cycle();
      guard++;
      if (spm == 1 ? model_alert : (model_done && (spm != 2 || model_alert))) post++;
    end
    check(guard < 4000, "R4 run timeout", guard, 4000);
    if (spm != 1) begin
      check(beats == BODYN, "R4 beat count", beats, BODYN);
      check(exp_addr_q.size() == 0, "R2 all addresses read", exp_addr_q.size(), 0);
      if (!corrupt) check(h_eng == h_ref && chk_good == 4'h6, "R6 intact image passes", chk_good, 4'h6);
      else check(chk_good == 4'h9, "R8 corrupted image fails", chk_good, 4'h9);
    end else begin
      check(beats < BODYN && !chk_done, "R11 stream halted", beats, 11);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    run(0, 2, 2, 1, 0);
    run(1, 0, 5, 2, 1);
    run(2, 1, 0, 3, 0);
    run(1, 0, 0, 4, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule